// File: doc/BRIEF.md
# SPI NAND Page Read Sequencer

This block performs one page read on a serial NAND device. It works through a byte-level transfer engine and does not toggle the serial pins itself. A single `start` pulse captures four request fields: a 24-bit row address, a 16-bit column offset, a byte count, and a raw flag. The block then runs three kinds of framed transactions:

- A page-load command, which moves the addressed page into the device's on-chip cache.
- A series of status-register reads, spaced by a programmable idle interval, until the ready bit clears.
- A cache-read command, which streams the requested bytes out on `rd_valid`/`rd_data`.

The last status byte carries the on-die ECC verdict. Outside raw mode, the block decodes that verdict into two running counters: bit flips corrected, and pages that could not be corrected. The cache read is still issued when the page could not be corrected, so the caller always receives the data. If the device stays busy for the whole polling budget, the block gives up without reading. It then reports a timeout on `result` alongside the `done` pulse.

The transfer engine sees `xfer_frame` high for the whole of one command. Each byte inside a frame is a request/acknowledge exchange: `xfer_dir` 0 means the block sends `xfer_wdata`, and `xfer_dir` 1 means it receives `xfer_rdata`.

Top module: `spinand_page_reader`

## Requirements
- R1: The first frame after `start` sends exactly four bytes: 0x13, then row bits [23:16], [15:8] and [7:0], in that order.
- R2: Each status frame sends 0x0F, then 0xC0, then receives one byte. A received byte with bit 0 set means busy, and another status frame follows.
- R3: Between two consecutive status frames, `xfer_frame` stays low for exactly POLL_GAP+1 cycles. Between any other two frames of one read, it stays low for exactly one cycle.
- R4: If the POLL_MAX-th status byte still shows busy, the block ends with `result` = 1 (timeout). It issues no cache read and leaves both counters unchanged.
- R5: In non-raw mode, if the final status byte has bits [6:4] = 3'b111, `fail_cnt` increases by one and `result` = 2.
- R6: In non-raw mode, if the final status bits [6:4] hold any value v other than 3'b111, `corr_cnt` increases by 2+v and `result` = 0.
- R7: The cache-read frame sends 0x03, 0x00, column bits [15:8], column bits [7:0], then receives exactly `req_len` bytes. Each received byte appears once on `rd_data`, in order, with `rd_valid` high. This happens whatever the ECC verdict was.
- R8: In raw mode, the ECC bits are ignored: neither counter changes and `result` = 0.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a single-cycle pulse, and `start` has no effect while `busy` is high.
- R10: After reset, `busy`, `done`, `xfer_frame` and `xfer_req` are low, and both counters are zero.
- R11: Frames are never merged. A read that completes produces 1 + (status reads) + 1 frames, and a timeout produces 1 + POLL_MAX frames.
- R12: A pending byte request holds `xfer_req`, `xfer_dir` and `xfer_wdata` steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a page read; sampled only when idle |
| req_row | input | 24 | Page (row) address |
| req_col | input | 16 | Column offset within the cache |
| req_len | input | LEN_W | Number of bytes to read from the cache |
| req_raw | input | 1 | 1 = skip ECC accounting |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 uncorrectable ECC; valid with `done` |
| corr_cnt | output | CNT_W | Running count of corrected bit flips |
| fail_cnt | output | CNT_W | Running count of uncorrectable pages |
| rd_valid | output | 1 | Cache data byte valid |
| rd_data | output | 8 | Cache data byte |
| xfer_frame | output | 1 | Transaction frame (chip-select span) |
| xfer_req | output | 1 | Byte exchange request |
| xfer_dir | output | 1 | 0 send `xfer_wdata`, 1 receive into `xfer_rdata` |
| xfer_wdata | output | 8 | Byte to send |
| xfer_ack | input | 1 | Byte exchange complete |
| xfer_rdata | input | 8 | Received byte, valid with `xfer_ack` |

## Verification
Each kind of wrong internal state shows up at the ports as follows:

- **Byte index.** A wrong byte index shows up in the very next byte the engine records: an opcode or address byte out of place, or a receive where a send should be.
- **Poll or gap counter.** A slipped counter changes the idle gap before the next status frame, or the number of status frames before the timeout. Either is visible within one poll interval.
- **ECC decode or raw gating.** A fault here is held in the counters. It can be read at `done` of the same read, a few cycles after the status byte that triggered it.
- **Length counter.** An off-by-one in the remaining-length counter changes how many bytes appear on `rd_data` before `done`.

// File: rtl/spinand_page_reader.sv
module spinand_page_reader #(
  parameter int POLL_GAP = 500,
  parameter int POLL_MAX = 100000,
  parameter int LEN_W    = 13,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      req_row,
  input  logic [15:0]      req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_raw,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic [CNT_W-1:0] corr_cnt,
  output logic [CNT_W-1:0] fail_cnt,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             xfer_frame,
  output logic             xfer_req,
  output logic             xfer_dir,
  output logic [7:0]       xfer_wdata,
  input  logic             xfer_ack,
  input  logic [7:0]       xfer_rdata
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam logic [1:0] RES_OK = 2'd0, RES_TIMEOUT = 2'd1, RES_ECC = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_STAT, S_WAIT, S_READ, S_GAP, S_FIN} st_t;

  st_t              st, nxt;
  logic [2:0]       idx;
  logic [LEN_W-1:0] rem;
  logic [23:0]      row;
  logic [15:0]      col;
  logic             raw, ecc_bad;
  logic [PW-1:0]    polls;
  logic [GW-1:0]    gcnt;
  logic             take;
  logic [2:0]       efield;

  assign xfer_frame = (st == S_LOAD) || (st == S_STAT) || (st == S_READ);
  assign xfer_req   = xfer_frame;
  assign xfer_dir   = ((st == S_STAT) && (idx == 3'd2)) || ((st == S_READ) && (idx == 3'd4));
  assign take       = xfer_req && xfer_ack;
  assign efield     = xfer_rdata[6:4];
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);

  always_comb begin
    xfer_wdata = 8'h00;
    case (st)
      S_LOAD: case (idx)
                3'd0:    xfer_wdata = 8'h13;
                3'd1:    xfer_wdata = row[23:16];
                3'd2:    xfer_wdata = row[15:8];
                default: xfer_wdata = row[7:0];
              endcase
      S_STAT: xfer_wdata = (idx == 3'd0) ? 8'h0F : 8'hC0;
      S_READ: case (idx)
                3'd0:    xfer_wdata = 8'h03;
                3'd1:    xfer_wdata = 8'h00;
                3'd2:    xfer_wdata = col[15:8];
                default: xfer_wdata = col[7:0];
              endcase
      default: xfer_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      nxt      <= S_IDLE;
      idx      <= '0;
      rem      <= '0;
      row      <= '0;
      col      <= '0;
      raw      <= 1'b0;
      ecc_bad  <= 1'b0;
      polls    <= '0;
      gcnt     <= '0;
      result   <= RES_OK;
      corr_cnt <= '0;
      fail_cnt <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          row     <= req_row;
          col     <= req_col;
          rem     <= req_len;
          raw     <= req_raw;
          ecc_bad <= 1'b0;
          polls   <= '0;
          idx     <= '0;
          st      <= S_LOAD;
        end
        S_LOAD: if (take) begin
          if (idx == 3'd3) begin
            idx <= '0;
            st  <= S_GAP;
            nxt <= S_STAT;
          end else idx <= idx + 3'd1;
        end
        S_STAT: if (take) begin
          if (idx != 3'd2) idx <= idx + 3'd1;
          else begin
            idx <= '0;
            st  <= S_GAP;
            if (xfer_rdata[0]) begin
              if (polls == PW'(POLL_MAX - 1)) begin
                result <= RES_TIMEOUT;
                nxt    <= S_FIN;
              end else begin
                polls <= polls + 1'b1;
                gcnt  <= '0;
                nxt   <= S_WAIT;
              end
            end else begin
              nxt <= S_READ;
              if (!raw) begin
                if (efield == 3'b111) begin
                  fail_cnt <= fail_cnt + CNT_W'(1);
                  ecc_bad  <= 1'b1;
                end else
                  corr_cnt <= corr_cnt + CNT_W'(efield) + CNT_W'(2);
              end
            end
          end
        end
        S_WAIT: if (gcnt == GW'(POLL_GAP - 1)) st <= S_STAT;
                else gcnt <= gcnt + 1'b1;
        S_READ: if (take) begin
          if (idx == 3'd4) begin
            rd_valid <= 1'b1;
            rd_data  <= xfer_rdata;
            rem      <= rem - 1'b1;
            if (rem == LEN_W'(1)) begin
              st     <= S_GAP;
              nxt    <= S_FIN;
              result <= ecc_bad ? RES_ECC : RES_OK;
            end
          end else if ((idx == 3'd3) && (rem == '0)) begin
            st     <= S_GAP;
            nxt    <= S_FIN;
            result <= ecc_bad ? RES_ECC : RES_OK;
          end else idx <= idx + 3'd1;
        end
        S_GAP:   st <= nxt;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_dir) && $stable(xfer_wdata))); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!xfer_frame && !xfer_req && !rd_valid)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R9
  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd3)); // R4
  AST_FAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cnt != $past(fail_cnt)) |-> (fail_cnt == $past(fail_cnt) + CNT_W'(1))); // R5
  AST_CORR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_cnt != $past(corr_cnt)) |->
      ((corr_cnt - $past(corr_cnt) >= CNT_W'(2)) && (corr_cnt - $past(corr_cnt) <= CNT_W'(8)))); // R6
  AST_RAW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && raw) |=> ($stable(corr_cnt) && $stable(fail_cnt))); // R8
  AST_DATA_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy); // R7
endmodule

// File: tb/spinand_page_reader_test.sv
module spinand_page_reader_test;
  localparam int GAP = 3, PMAX = 4, LW = 6, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 1'b0, req_raw = 1'b0;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic [LW-1:0] req_len = '0;
  logic busy, done, rd_valid, xfer_frame, xfer_req, xfer_dir;
  logic [1:0] result;
  logic [CW-1:0] corr_cnt, fail_cnt;
  logic [7:0] rd_data, xfer_wdata;
  logic xfer_ack = 1'b0;
  logic [7:0] xfer_rdata = '0;

  spinand_page_reader #(.POLL_GAP(GAP), .POLL_MAX(PMAX), .LEN_W(LW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_row(req_row), .req_col(req_col),
    .req_len(req_len), .req_raw(req_raw), .busy(busy), .done(done), .result(result),
    .corr_cnt(corr_cnt), .fail_cnt(fail_cnt), .rd_valid(rd_valid), .rd_data(rd_data),
    .xfer_frame(xfer_frame), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
    .xfer_wdata(xfer_wdata), .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata));

  int checks = 0, fails = 0;
  int lat = 0, busy_n = 0;
  logic [7:0] fin_stat = '0;
  int dly = 0, bif = 0, stat_k = 0, rxi = 0, lowrun = 0, last_gap = 0, gap_err = 0;
  int tx_n = 0, rd_i = 0, rd_err = 0;
  logic [7:0] op = '0;
  logic [7:0] tx_log [0:63];
  logic pf = 1'b0;
  logic [15:0] cur_col = '0;
  longint exp_corr = 0, exp_fail = 0;

  function automatic logic [7:0] dat(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5B;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // transfer engine model and monitors
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_data != dat(cur_col + 16'(rd_i))) rd_err++;
      rd_i++;
    end
    if (xfer_frame && !pf) begin bif = 0; rxi = 0; last_gap = lowrun; lowrun = 0; end
    if (!xfer_frame) lowrun++;
    pf = xfer_frame;
    if (xfer_ack) xfer_ack = 1'b0;
    else if (xfer_req) begin
      if (dly >= lat) begin
        dly = 0;
        xfer_ack = 1'b1;
        if (bif == 0) begin
          op = xfer_wdata;
          if (op == 8'h0F) begin
            if (last_gap != ((stat_k > 0) ? GAP + 1 : 1)) gap_err++;
          end else if (op == 8'h03 && last_gap != 1) gap_err++;
        end
        if (!xfer_dir) begin
          if (tx_n < 64) tx_log[tx_n] = xfer_wdata;
          tx_n++;
        end else if (op == 8'h0F) begin
          xfer_rdata = (stat_k < busy_n) ? 8'h71 : fin_stat;
          stat_k++;
        end else begin
          xfer_rdata = dat(cur_col + 16'(rxi));
          rxi++;
        end
        bif++;
      end else dly++;
    end
  end

  task automatic run_op(input logic [23:0] row, input logic [15:0] col, input int len,
                        input bit raw, input int bn, input logic [2:0] ecc, input int lt);
    bit to;
    int nstat, cyc, bad, h;
    logic [1:0] er;
    to = (bn >= PMAX);
    nstat = to ? PMAX : bn + 1;
    tx_n = 0; stat_k = 0; rd_i = 0; rd_err = 0; gap_err = 0; dly = 0;
    cur_col = col; busy_n = bn; lat = lt; fin_stat = {1'b1, ecc, 4'b0100};
    @(negedge clk);
    req_row = row; req_col = col; req_len = LW'(len); req_raw = raw; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    if (!done) begin fails++; $display("FAIL R9: watchdog, done never seen"); end
    er = to ? 2'd1 : (!raw && ecc == 3'b111) ? 2'd2 : 2'd0;
    if (!to && !raw) begin
      if (ecc == 3'b111) exp_fail++;
      else exp_corr += 2 + ecc;
    end
    bad = 0;
    if (tx_log[0] != 8'h13) bad++;
    if (tx_log[1] != row[23:16]) bad++;
    if (tx_log[2] != row[15:8]) bad++;
    if (tx_log[3] != row[7:0]) bad++;
    chk(bad == 0, "R1 load bytes", bad, 0);
    bad = 0;
    for (int k = 0; k < nstat; k++)
      if (tx_log[4 + 2*k] != 8'h0F || tx_log[5 + 2*k] != 8'hC0) bad++;
    chk(stat_k == nstat, "R2 status reads", stat_k, nstat);
    chk(bad == 0, "R2 status bytes", bad, 0);
    chk(gap_err == 0, "R3 frame gaps", gap_err, 0);
    chk(tx_n == (to ? 4 : 8) + 2*nstat, "R11 frames/bytes sent", tx_n, (to ? 4 : 8) + 2*nstat);
    if (!to) begin
      h = 4 + 2*nstat;
      bad = 0;
      if (tx_log[h] != 8'h03) bad++;
      if (tx_log[h+1] != 8'h00) bad++;
      if (tx_log[h+2] != col[15:8]) bad++;
      if (tx_log[h+3] != col[7:0]) bad++;
      chk(bad == 0, "R7 cache read header", bad, 0);
      chk(rd_i == len, "R7 data count", rd_i, len);
      chk(rd_err == 0, "R7 data values", rd_err, 0);
    end else
      chk(rd_i == 0, "R4 no data on timeout", rd_i, 0);
    chk(result == er, to ? "R4 result" : raw ? "R8 result" : (ecc == 3'b111) ? "R5 result" : "R6 result",
        result, er);
    chk(corr_cnt == CW'(exp_corr), raw ? "R8 corr_cnt" : "R6 corr_cnt", corr_cnt, exp_corr);
    chk(fail_cnt == CW'(exp_fail), raw ? "R8 fail_cnt" : "R5 fail_cnt", fail_cnt, exp_fail);
    @(negedge clk);
    chk(!done && !busy, "R9 single done, held start ignored", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !xfer_frame && !xfer_req, "R10 idle outputs", {busy, done, xfer_frame, xfer_req}, 0);
    chk(corr_cnt == 0 && fail_cnt == 0, "R10 counters", {corr_cnt, fail_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 2; r++)
      for (int e = 0; e < 8; e++)
        for (int b = 0; b < 3; b++) begin
          int i;
          i = r*24 + e*3 + b;
          run_op({8'(i*37), 8'(i*5+1), 8'(i)}, 16'(i*300 + 7), (e + b) % 5, r[0],
                 (b == 2) ? 3 : b, 3'(e), i % 2);
        end
    run_op(24'hABCDEF, 16'h1234, 3, 1'b0, PMAX, 3'd2, 0);
    run_op(24'h000001, 16'hFFFE, 2, 1'b1, PMAX + 2, 3'd7, 1);
    run_op(24'hFFFFFF, 16'h0000, 1, 1'b0, 0, 3'd0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule